// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a PWM generator and the pins of a complementary high/low output pair. Under normal conditions it passes the generator's active-level signals to the pins, translated through a per-pin polarity setting. When the external fault input goes high, it forces both pins to fault levels straight away, through logic with no clock edge in the path. It then decides, by clocked logic, when normal drive may resume.

A two-bit mode setting picks the fault response. In latched mode each pin takes a programmed fault-data level. In cycle-by-cycle mode the pair is held in the deasserted PWM state. The third setting stops the fault from touching the pins. Exit from latched mode needs both the released fault input and a cleared interrupt flag. Exit from cycle-by-cycle mode needs only the released input. In both modes the pins resume at the next period start of the time base, unless the time base is stopped. The fault input also raises an interrupt flag when interrupts are enabled, in every mode. This lets the pin serve as a general-purpose interrupt source when the override is turned off.

Top module: `pwm_fault_guard`

## Requirements
- R1: With the mode field at 2'b10 or 2'b11 (override off), the pins follow normal drive even while the fault input is high, and the fault status output stays 0.
- R2: In normal drive each pin equals its generator signal XOR its polarity bit (polarity 0 means active-high, polarity 1 means active-low).
- R3: With the mode field at 2'b00 (latched), a high fault input sets each pin at once, with no clock edge, to its fault-data bit XOR its polarity bit. A fault-data bit of 1 gives the active level and 0 gives the inactive level.
- R4: With the mode field at 2'b01 (cycle-by-cycle), a high fault input sets the high pin at once to its inactive level (equal to its polarity bit) and the low pin to its active level (the inverse of its polarity bit).
- R5: In latched mode the pins stay overridden until three conditions all hold at one clock edge: the synchronized fault input is low, the interrupt flag is 0, and the time-base counter is zero (when the time base runs). Normal drive returns after that edge.
- R6: In latched mode, clearing the interrupt flag while the fault input is still high does not end the override. Exit follows the release of the input and then a period start.
- R7: In cycle-by-cycle mode the pins return to normal drive after the first clock edge at which the synchronized fault input is low and the time-base counter is zero. The interrupt flag has no part in this exit.
- R8: With the time-base enable low, neither mode waits for a zero count. Cycle-by-cycle restores on the third edge after the fault input falls. Latched mode restores there too, once the flag is 0.
- R9: When the interrupt enable is 1, the interrupt flag is set on the rising edge of the fault input after a two-flop synchronizer (it is 1 after the third clock edge following the input's rise), in every mode. The flag then holds until a clear strobe; a set in the same cycle wins over the strobe.
- R10: While the interrupt enable is 0 the interrupt flag is held at 0: it clears on the next edge and new fault edges do not set it.
- R11: The fault status output is 1 while the clocked override state is held. An asynchronous active-low reset clears the status, the flag and the held state, leaving the pins in normal drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 1 | Raw external fault input, high means fault |
| gen_hi | input | 1 | Generator drive for the high pin, 1 = active |
| gen_lo | input | 1 | Generator drive for the low pin, 1 = active |
| tb_count | input | CNT_W | PWM time-base counter, zero marks a period start |
| tb_enable | input | 1 | Time base running |
| mode | input | 2 | 00 latched, 01 cycle-by-cycle, 1x override off |
| fdat_hi | input | 1 | Fault level of the high pin, 1 = active |
| fdat_lo | input | 1 | Fault level of the low pin, 1 = active |
| pol_hi | input | 1 | Polarity of the high pin, 1 = active-low |
| pol_lo | input | 1 | Polarity of the low pin, 1 = active-low |
| irq_en | input | 1 | Interrupt enable; 0 clears the flag |
| flag_clr | input | 1 | One-cycle software clear of the interrupt flag |
| pin_hi | output | 1 | Final high pin level |
| pin_lo | output | 1 | Final low pin level |
| irq_flag | output | 1 | Fault interrupt flag |
| fault_stat | output | 1 | Clocked override state held |

## Verification
Some properties are checked on every clock cycle. The pin levels must match the mode-specific fault levels whenever the raw input is high, and must match normal drive when the override is off. The held state must never drop while the flag is set in latched mode or while the synchronized input is high. Any drop of the held state must follow a cycle with a zero count or a stopped time base. The flag must keep its value unless cleared, and must stay low while interrupts are disabled. Only the bench scenarios show the exact exit cycle in each mode, the synchronizer latency of the flag, and the sequence where the flag is cleared before the fault is released.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    FM_LATCH = 2'b00,
    FM_CYCLE = 2'b01,
    FM_OFF_A = 2'b10,
    FM_OFF_B = 2'b11
  } fault_mode_e;

  // Pin level for a logical active/inactive value under a polarity bit.
  function automatic logic drive_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction

  // True for the modes in which the fault input may take over the pins.
  function automatic logic mode_overrides(input logic [1:0] m);
    return (m == FM_LATCH) || (m == FM_CYCLE);
  endfunction

  // Logical fault level of a lane: lane 1 is the high pin, lane 0 the low pin.
  function automatic logic fault_active(input logic [1:0] m, input int lane,
                                        input logic fdat);
    if (m == FM_CYCLE) return (lane == 0);
    return fdat;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[LAST-1:0], din};
      prev  <= chain[LAST];
    end
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~prev;

  // R9: a rising-edge pulse lasts exactly one cycle
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pfg_flag.sv
module pfg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic irq_en,
  input  logic clr,
  output logic flag
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag;
    if (!irq_en)   flag_nxt = 1'b0;
    else if (rise) flag_nxt = 1'b1;
    else if (clr)  flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nxt;
  end

  // R9: an enabled edge always sets the flag
  a_r9_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && irq_en) |=> flag);

  // R9: without a clear the flag holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en && !clr) |=> flag);

  // R10: disabled interrupts keep the flag low
  a_r10_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !flag);

endmodule

// File: rtl/pfg_hold.sv
module pfg_hold
  import pfg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_lvl,
  input  logic [1:0]       mode,
  input  logic             flag,
  input  logic [CNT_W-1:0] tb_count,
  input  logic             tb_enable,
  output logic             held,
  output logic             exit_ok
);
  logic ovr_mode;
  logic period_ok;
  logic flag_ok;
  logic held_nxt;

  assign ovr_mode  = mode_overrides(mode);
  assign period_ok = !tb_enable || (tb_count == '0);
  assign flag_ok   = (fault_mode_e'(mode) == FM_CYCLE) || !flag;
  assign exit_ok   = !sync_lvl && flag_ok && period_ok;

  always_comb begin
    held_nxt = held;
    if (!ovr_mode)            held_nxt = 1'b0;
    else if (sync_lvl)        held_nxt = 1'b1;
    else if (held && exit_ok) held_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_nxt;
  end

  // R5: latched override cannot end while the flag is set
  a_r5_latch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mode_e'(mode) == FM_LATCH && held && flag) |=> held);

  // R6: override cannot end while the synchronized input is high
  a_r6_input_high: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sync_lvl && ovr_mode) |=> held);

  // R7/R8: exit only at a period start, a stopped time base or override off
  a_r7_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(period_ok || !ovr_mode));

endmodule

// File: rtl/pfg_outmux.sv
module pfg_outmux
  import pfg_pkg::*;
(
  input  logic       fault_raw,
  input  logic       held,
  input  logic [1:0] mode,
  input  logic [1:0] gen_v,
  input  logic [1:0] fdat_v,
  input  logic [1:0] pol_v,
  output logic [1:0] pin_v,
  output logic       override
);
  assign override = mode_overrides(mode) && (fault_raw || held);

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic act;
    always_comb begin
      if (override) act = fault_active(mode, lane, fdat_v[lane]);
      else          act = gen_v[lane];
    end
    assign pin_v[lane] = drive_level(act, pol_v[lane]);
  end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_pin,
  input  logic             gen_hi,
  input  logic             gen_lo,
  input  logic [CNT_W-1:0] tb_count,
  input  logic             tb_enable,
  input  logic [1:0]       mode,
  input  logic             fdat_hi,
  input  logic             fdat_lo,
  input  logic             pol_hi,
  input  logic             pol_lo,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             pin_hi,
  output logic             pin_lo,
  output logic             irq_flag,
  output logic             fault_stat
);
  logic       sync_lvl;
  logic       sync_rise;
  logic       held;
  logic       exit_ok;
  logic       override;
  logic [1:0] pin_v;

  pfg_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(fault_pin),
    .lvl(sync_lvl), .rise(sync_rise)
  );

  pfg_flag u_flag (
    .clk(clk), .rst_n(rst_n), .rise(sync_rise), .irq_en(irq_en),
    .clr(flag_clr), .flag(irq_flag)
  );

  pfg_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .mode(mode),
    .flag(irq_flag), .tb_count(tb_count), .tb_enable(tb_enable),
    .held(held), .exit_ok(exit_ok)
  );

  pfg_outmux u_mux (
    .fault_raw(fault_pin), .held(held), .mode(mode),
    .gen_v({gen_hi, gen_lo}), .fdat_v({fdat_hi, fdat_lo}),
    .pol_v({pol_hi, pol_lo}), .pin_v(pin_v), .override(override)
  );

  assign pin_hi     = pin_v[1];
  assign pin_lo     = pin_v[0];
  assign fault_stat = held;

  // R1: override off passes normal drive through
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (pin_hi == (gen_hi ^ pol_hi)) && (pin_lo == (gen_lo ^ pol_lo))
                && !fault_stat);

  // R3: latched fault levels while the raw input is high
  a_r3_latched_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && fault_pin) |->
      (pin_hi == (fdat_hi ^ pol_hi)) && (pin_lo == (fdat_lo ^ pol_lo)));

  // R4: deasserted pair while the raw input is high in cycle-by-cycle mode
  a_r4_cycle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && fault_pin) |-> (pin_hi == pol_hi) && (pin_lo == !pol_lo));

  // R8: a held state with a clear exit path in a stopped time base leaves
  a_r8_tb_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (held && exit_ok && !tb_enable) |=> !held);

endmodule

// File: tb/pwm_fault_guard_test.sv
`timescale 1ns/1ps
module pwm_fault_guard_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_pin = 1'b0, gen_hi = 1'b0, gen_lo = 1'b0;
  logic [CW-1:0] tb_count = 3;
  logic tb_enable = 1'b1;
  logic [1:0] mode = 2'b00;
  logic fdat_hi = 1'b0, fdat_lo = 1'b0, pol_hi = 1'b0, pol_lo = 1'b0;
  logic irq_en = 1'b1, flag_clr = 1'b0;
  logic pin_hi, pin_lo, irq_flag, fault_stat;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm_fault_guard #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .gen_hi(gen_hi),
    .gen_lo(gen_lo), .tb_count(tb_count), .tb_enable(tb_enable), .mode(mode),
    .fdat_hi(fdat_hi), .fdat_lo(fdat_lo), .pol_hi(pol_hi), .pol_lo(pol_lo),
    .irq_en(irq_en), .flag_clr(flag_clr), .pin_hi(pin_hi), .pin_lo(pin_lo),
    .irq_flag(irq_flag), .fault_stat(fault_stat)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    fault_pin = 1'b0; flag_clr = 1'b0; irq_en = 1'b1;
    tb_enable = 1'b1; tb_count = 3;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 2'b00; gen_hi = 1'b1; gen_lo = 1'b0;
    pol_hi = 1'b0; pol_lo = 1'b1;
    #1;
    chk("R11 reset flag/stat", {irq_flag, fault_stat}, 2'b00);
    chk("R11 reset pins normal", {pin_hi, pin_lo}, 2'b11);
    do_reset();
  endtask

  task automatic t_normal();
    mode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      gen_hi = k[0]; gen_lo = ~k[0]; pol_hi = k[1]; pol_lo = k[0];
      #1;
      chk("R2 normal drive", {pin_hi, pin_lo},
          {gen_hi ^ pol_hi, gen_lo ^ pol_lo});
    end
  endtask

  task automatic t_latched();
    do_reset();
    mode = 2'b00; fdat_hi = 1'b1; fdat_lo = 1'b0; pol_hi = 1'b0; pol_lo = 1'b1;
    gen_hi = 1'b0; gen_lo = 1'b1;
    #1;
    chk("R2 latched pre", {pin_hi, pin_lo}, 2'b00);
    fault_pin = 1'b1;
    #1;
    chk("R3 immediate latched levels", {pin_hi, pin_lo}, 2'b11);
    cyc(2);
    chk("R9 flag not yet set after 2 edges", {irq_flag, 1'b0}, 2'b00);
    cyc(1);
    chk("R9 flag set after 3 edges", {irq_flag, fault_stat}, 2'b11);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R9 flag cleared by strobe", {irq_flag, fault_stat}, 2'b01);
    tb_count = 0; cyc(4);
    chk("R6 still held while input high", {fault_stat, pin_hi, pin_lo}, 3'b111);
    fault_pin = 1'b0; tb_count = 3; cyc(4);
    chk("R5 waits for period start", {pin_hi, pin_lo}, 2'b11);
    tb_count = 0; cyc(1);
    chk("R5 restored after zero count", {pin_hi, pin_lo}, 2'b00);
    chk("R11 status cleared on exit", {fault_stat, 1'b0}, 2'b00);
  endtask

  task automatic t_latched_noclr();
    do_reset();
    mode = 2'b00; fdat_hi = 1'b0; fdat_lo = 1'b1; pol_hi = 1'b0; pol_lo = 1'b0;
    gen_hi = 1'b1; gen_lo = 1'b0;
    fault_pin = 1'b1; cyc(4);
    fault_pin = 1'b0; tb_count = 0; cyc(5);
    chk("R5 flag set blocks exit", {pin_hi, pin_lo}, 2'b01);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R5 exit not on clearing edge", {pin_hi, pin_lo}, 2'b01);
    cyc(1);
    chk("R5 exit on next zero-count edge", {pin_hi, pin_lo}, 2'b10);
  endtask

  task automatic t_cycle();
    do_reset();
    mode = 2'b01; fdat_hi = 1'b1; fdat_lo = 1'b1; pol_hi = 1'b0; pol_lo = 1'b0;
    gen_hi = 1'b1; gen_lo = 1'b0;
    fault_pin = 1'b1;
    #1;
    chk("R4 deasserted pair", {pin_hi, pin_lo}, 2'b01);
    pol_hi = 1'b1; pol_lo = 1'b1;
    #1;
    chk("R4 deasserted pair inverted polarity", {pin_hi, pin_lo}, 2'b10);
    pol_hi = 1'b0; pol_lo = 1'b0;
    cyc(4);
    fault_pin = 1'b0; tb_count = 5; cyc(5);
    chk("R7 waits for period start", {pin_hi, pin_lo}, 2'b01);
    tb_count = 0; cyc(1);
    chk("R7 restored with flag still set", {pin_hi, pin_lo, irq_flag}, 3'b101);
  endtask

  task automatic t_tb_off();
    do_reset();
    mode = 2'b01; pol_hi = 1'b0; pol_lo = 1'b0; gen_hi = 1'b1; gen_lo = 1'b0;
    tb_enable = 1'b0; tb_count = 5;
    fault_pin = 1'b1; cyc(4);
    fault_pin = 1'b0; cyc(1);
    chk("R8 cycle still held after 1 edge", {pin_hi, pin_lo}, 2'b01);
    cyc(2);
    chk("R8 cycle restored without zero count", {pin_hi, pin_lo}, 2'b10);
    do_reset();
    mode = 2'b00; fdat_hi = 1'b0; fdat_lo = 1'b0; tb_enable = 1'b0; tb_count = 5;
    fault_pin = 1'b1; cyc(4);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    fault_pin = 1'b0; cyc(4);
    chk("R8 latched restored without zero count", {pin_hi, pin_lo}, 2'b10);
  endtask

  task automatic t_disabled();
    do_reset();
    mode = 2'b10; pol_hi = 1'b1; pol_lo = 1'b0; gen_hi = 1'b0; gen_lo = 1'b1;
    fdat_hi = 1'b0; fdat_lo = 1'b0;
    fault_pin = 1'b1;
    #1;
    chk("R1 pins unaffected", {pin_hi, pin_lo}, 2'b11);
    cyc(3);
    chk("R9 flag as plain interrupt", {irq_flag, fault_stat}, 2'b10);
    mode = 2'b11;
    #1;
    chk("R1 mode 11 pins unaffected", {pin_hi, pin_lo}, 2'b11);
    fault_pin = 1'b0; cyc(3);
  endtask

  task automatic t_irq_off();
    do_reset();
    mode = 2'b10;
    fault_pin = 1'b1; cyc(4);
    chk("R10 precondition flag set", {irq_flag, 1'b0}, 2'b10);
    irq_en = 1'b0; cyc(1);
    chk("R10 flag cleared by enable low", {irq_flag, 1'b0}, 2'b00);
    fault_pin = 1'b0; cyc(3);
    fault_pin = 1'b1; cyc(4);
    chk("R10 new edge ignored", {irq_flag, 1'b0}, 2'b00);
    fault_pin = 1'b0; cyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_latched();
    t_latched_noclr();
    t_cycle();
    t_tb_off();
    t_disabled();
    t_irq_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule